// File: doc/BRIEF.md
# SIMT lane execution mask unit

This block holds the lane-enable register of a scalar control unit that steers a group of vector lanes. Bit i of the register enables lane i. A lane whose bit is clear must not commit results. The block runs the mask operations that lower structured if/else/loop code into predication. It saves and narrows the enable set at an if, flips to the untaken lanes at an else, and restores the saved lanes at the end of a region. At a loop end it retires the lanes that have finished, and it accumulates break masks. Divergent control flow therefore needs no per-lane branching.

Each cycle the block takes an operation code, a condition mask and a scalar source operand. The vector lanes fill the condition mask with one compare result per lane. The scalar destination value, its write-enable and the two branch-taken flags are combinational results of the current operation. The lane-enable register updates on the next rising clock edge. Both branch flags are judged on the enable value that the current operation produces. A loop-end operation therefore gives its own continue decision in the same cycle.

Top module: `lane_mask_unit`

## Requirements
- R1: After reset the lane-enable output `exec_o` is all ones. With opcode 0 (no-op), `dst_we_o`, `take_z_o` and `take_nz_o` are low and `exec_o` holds.
- R2: Opcode 1 (and-save) drives the old enable value on `dst_o` with `dst_we_o` high. At the next edge it sets the enable to old AND `cond_i`.
- R3: Opcode 2 (or-save) drives the old enable value on `dst_o` with `dst_we_o` high. At the next edge it sets the enable to old OR `src_i`.
- R4: Opcode 3 writes enable XOR `src_i` to `dst_o` and leaves the enable unchanged. Opcode 4 writes enable XOR `src_i` into the enable register and leaves `dst_we_o` low.
- R5: Opcode 5 (end-of-region) sets the enable to enable OR `src_i` and leaves `dst_we_o` low. No previously enabled lane is dropped.
- R6: Opcode 6 (loop-end) sets the enable to enable AND NOT `src_i`. In the same cycle, `take_nz_o` is high exactly when that new value is non-zero.
- R7: The break opcodes drive `dst_o` with `dst_we_o` high and leave the enable unchanged. Opcode 7 gives enable OR `src_i`. Opcode 8 gives `cond_i` OR `src_i`. Opcode 9 gives a saved mask presented on `cond_i` OR the accumulated mask on `src_i`.
- R8: Opcode 10 (branch-if-zero) raises `take_z_o` only when all lane bits of the enable are zero. A single set bit, including the top lane, keeps it low. The enable is unchanged.
- R9: Opcode 11 (branch-if-nonzero) raises `take_nz_o` exactly when the enable is non-zero. The enable is unchanged.
- R10: Opcodes 12 to 15 leave the enable unchanged, keep `dst_we_o` low and raise neither branch flag.
- R11: At most one of `take_z_o` and `take_nz_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Mask operation code |
| cond_i | input | LANES | Per-lane compare result mask, or a saved mask for opcode 9 |
| src_i | input | LANES | Scalar source operand |
| dst_o | output | LANES | Scalar destination value |
| dst_we_o | output | 1 | Destination write-enable |
| exec_o | output | LANES | Lane-enable register, driven to the lanes |
| take_z_o | output | 1 | Branch taken: enable is all zero |
| take_nz_o | output | 1 | Branch taken: enable is non-zero |

## Verification
The bench builds the block with 64 lanes and 8-lane groups in the zero-detect tree. This covers the full register width and puts the top lane in the last group, where a padding or group-indexing error would show. It walks a full if/else/end sequence and a loop that drains lanes until the continue flag drops. It probes the zero test with a single live bit at lane 0, at lane 63 and at a mid-group lane.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP       = 4'd0,
    OP_AND_SAVE  = 4'd1,
    OP_OR_SAVE   = 4'd2,
    OP_XOR_DST   = 4'd3,
    OP_XOR_EXEC  = 4'd4,
    OP_END_REG   = 4'd5,
    OP_LOOP_END  = 4'd6,
    OP_BRK_EXEC  = 4'd7,
    OP_BRK_COND  = 4'd8,
    OP_BRK_SAVED = 4'd9,
    OP_BR_ZERO   = 4'd10,
    OP_BR_NZERO  = 4'd11
  } mask_op_e;
endpackage

// File: rtl/mask_alu.sv
module mask_alu
  import lane_mask_pkg::*;
#(
  parameter int unsigned LANES = 64
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [LANES-1:0] exec_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] src_i,
  output logic [LANES-1:0] exec_nxt_o,
  output logic             exec_we_o,
  output logic [LANES-1:0] dst_o,
  output logic             dst_we_o,
  output logic             br_z_o,
  output logic             br_nz_o
);
  always_comb begin
    exec_nxt_o = exec_i;
    exec_we_o  = 1'b0;
    dst_o      = '0;
    dst_we_o   = 1'b0;
    br_z_o     = 1'b0;
    br_nz_o    = 1'b0;
    case (op_i)
      OP_AND_SAVE: begin
        dst_o = exec_i; dst_we_o = 1'b1;
        exec_nxt_o = exec_i & cond_i; exec_we_o = 1'b1;
      end
      OP_OR_SAVE: begin
        dst_o = exec_i; dst_we_o = 1'b1;
        exec_nxt_o = exec_i | src_i; exec_we_o = 1'b1;
      end
      OP_XOR_DST: begin
        dst_o = exec_i ^ src_i; dst_we_o = 1'b1;
      end
      OP_XOR_EXEC: begin
        exec_nxt_o = exec_i ^ src_i; exec_we_o = 1'b1;
      end
      OP_END_REG: begin
        exec_nxt_o = exec_i | src_i; exec_we_o = 1'b1;
      end
      OP_LOOP_END: begin
        exec_nxt_o = exec_i & ~src_i; exec_we_o = 1'b1;
        br_nz_o = 1'b1;  // fused continue test on the new mask
      end
      OP_BRK_EXEC: begin
        dst_o = exec_i | src_i; dst_we_o = 1'b1;
      end
      OP_BRK_COND, OP_BRK_SAVED: begin
        dst_o = cond_i | src_i; dst_we_o = 1'b1;
      end
      OP_BR_ZERO:  br_z_o  = 1'b1;
      OP_BR_NZERO: br_nz_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
  parameter int unsigned LANES = 64,
  parameter int unsigned GROUP = 8
) (
  input  logic [LANES-1:0] vec_i,
  output logic             any_o
);
  localparam int unsigned NGRP = (LANES + GROUP - 1) / GROUP;
  localparam int unsigned PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_any;

  generate
    if (PADW > LANES) begin : g_pad
      assign padded = {{(PADW-LANES){1'b0}}, vec_i};
    end else begin : g_nopad
      assign padded = vec_i;
    end
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_any[g] = |padded[g*GROUP +: GROUP];
    end
  endgenerate

  assign any_o = |grp_any;
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int unsigned LANES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= d_i;
  end

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> q_o == $past(q_o));
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
  import lane_mask_pkg::*;
#(
  parameter int unsigned LANES = 64,
  parameter int unsigned GROUP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] src_i,
  output logic [LANES-1:0] dst_o,
  output logic             dst_we_o,
  output logic [LANES-1:0] exec_o,
  output logic             take_z_o,
  output logic             take_nz_o
);
  logic [LANES-1:0] exec_nxt;
  logic             exec_we, br_z, br_nz, nxt_any;

  mask_alu #(.LANES(LANES)) u_alu (
    .op_i(op_i), .exec_i(exec_o), .cond_i(cond_i), .src_i(src_i),
    .exec_nxt_o(exec_nxt), .exec_we_o(exec_we),
    .dst_o(dst_o), .dst_we_o(dst_we_o),
    .br_z_o(br_z), .br_nz_o(br_nz)
  );

  zero_detect #(.LANES(LANES), .GROUP(GROUP)) u_zd (
    .vec_i(exec_nxt), .any_o(nxt_any)
  );

  mask_reg #(.LANES(LANES)) u_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(exec_we),
    .d_i(exec_nxt), .q_o(exec_o)
  );

  assign take_z_o  = br_z  & ~nxt_any;
  assign take_nz_o = br_nz &  nxt_any;

  assert_and_save_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_AND_SAVE |-> dst_we_o && dst_o == exec_o);
  assert_and_narrow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_AND_SAVE |=> (exec_o & ~$past(cond_i)) == '0);
  assert_end_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_END_REG |=> (exec_o & $past(exec_o)) == $past(exec_o));
  assert_loop_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOOP_END |=> (exec_o & $past(src_i)) == '0);
  assert_loop_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOOP_END |=> $past(take_nz_o) == (exec_o != '0));
  assert_brz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_z_o |-> exec_o == '0);
  assert_unknown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > OP_BR_NZERO |-> !dst_we_o && !take_z_o && !take_nz_o);
  assert_unknown_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > OP_BR_NZERO |=> $stable(exec_o));
  assert_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_z_o, take_nz_o}));
endmodule

// File: tb/lane_mask_unit_bench.sv
module lane_mask_unit_bench;
  localparam int unsigned L = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op = 4'd0;
  logic [L-1:0] cond = '0, src = '0;
  logic [L-1:0] dst, exec_v;
  logic         dst_we, tz, tnz;
  int           n_run = 0, n_fail = 0;
  logic [L-1:0] mdl;

  always #2 clk = ~clk;

  lane_mask_unit #(.LANES(L), .GROUP(8)) u_lane_mask_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .cond_i(cond), .src_i(src),
    .dst_o(dst), .dst_we_o(dst_we), .exec_o(exec_v),
    .take_z_o(tz), .take_nz_o(tnz)
  );

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check comb outputs, commit at posedge, check exec
  task automatic step(input string req, input logic [3:0] o, input logic [L-1:0] c,
                      input logic [L-1:0] s, input logic we_e, input logic [L-1:0] dst_e,
                      input logic tz_e, input logic tnz_e, input logic [L-1:0] ex_e);
    op = o; cond = c; src = s;
    #1;
    chk({req, " we"}, L'(dst_we), L'(we_e));
    if (we_e) chk({req, " dst"}, dst, dst_e);
    chk({req, " tz"}, L'(tz), L'(tz_e));
    chk({req, " tnz"}, L'(tnz), L'(tnz_e));
    @(negedge clk);
    chk({req, " exec"}, exec_v, ex_e);
    mdl = ex_e;
    op = 4'd0;
  endtask

  task automatic set_exec(input logic [L-1:0] v);
    // xor-into-exec reaches any value
    step("R4 setup", 4'd4, '0, mdl ^ v, 1'b0, '0, 1'b0, 1'b0, v);
  endtask

  task automatic t_reset;
    chk("R1 reset exec", exec_v, '1);
    mdl = '1;
    step("R1 nop", 4'd0, '1, '1, 1'b0, '0, 1'b0, 1'b0, '1);
  endtask

  task automatic t_if_else;
    logic [L-1:0] c = 64'h00FF_F0F0_1234_8001;
    logic [L-1:0] saved;
    set_exec('1);
    step("R2 and-save", 4'd1, c, '0, 1'b1, '1, 1'b0, 1'b0, c);
    step("R4 xor-dst", 4'd3, '0, '1, 1'b1, ~c, 1'b0, 1'b0, c);
    saved = ~c;
    step("R3 or-save", 4'd2, '0, saved, 1'b1, c, 1'b0, 1'b0, '1);
    step("R4 xor-exec", 4'd4, '0, c, 1'b0, '0, 1'b0, 1'b0, ~c);
    step("R5 end-region", 4'd5, '0, c, 1'b0, '0, 1'b0, 1'b0, '1);
    set_exec(64'hA5A5_0000_0000_5A5A);
    step("R2 and-save partial", 4'd1, 64'hFFFF_0000_0000_000F, '0, 1'b1,
         64'hA5A5_0000_0000_5A5A, 1'b0, 1'b0, 64'hA5A5_0000_0000_000A);
    step("R5 end-region keep", 4'd5, '0, 64'h0000_0000_0000_0100, 1'b0, '0, 1'b0, 1'b0,
         64'hA5A5_0000_0000_010A);
  endtask

  task automatic t_loop;
    set_exec(64'h8000_0000_0000_0003);
    step("R6 loop partial", 4'd6, '0, 64'h1, 1'b0, '0, 1'b0, 1'b1, 64'h8000_0000_0000_0002);
    step("R6 loop partial2", 4'd6, '0, 64'h2, 1'b0, '0, 1'b0, 1'b1, 64'h8000_0000_0000_0000);
    step("R6 loop exit", 4'd6, '0, 64'h8000_0000_0000_0000, 1'b0, '0, 1'b0, 1'b0, '0);
    step("R9 brnz zero", 4'd11, '0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    step("R8 brz zero", 4'd10, '0, '0, 1'b0, '0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_breaks;
    set_exec(64'h0000_00F0_0000_0000);
    step("R7 brk exec", 4'd7, 64'hFFFF, 64'h3, 1'b1, 64'h0000_00F0_0000_0003, 1'b0, 1'b0,
         64'h0000_00F0_0000_0000);
    step("R7 brk cond", 4'd8, 64'hC000_0000_0000_0000, 64'h3, 1'b1, 64'hC000_0000_0000_0003,
         1'b0, 1'b0, 64'h0000_00F0_0000_0000);
    step("R7 brk saved", 4'd9, 64'h0F00, 64'h1_0000, 1'b1, 64'h1_0F00, 1'b0, 1'b0,
         64'h0000_00F0_0000_0000);
  endtask

  task automatic t_zero_tests;
    set_exec(64'h8000_0000_0000_0000);
    step("R8 brz top lane", 4'd10, '0, '0, 1'b0, '0, 1'b0, 1'b0, 64'h8000_0000_0000_0000);
    step("R9 brnz top lane", 4'd11, '0, '0, 1'b0, '0, 1'b0, 1'b1, 64'h8000_0000_0000_0000);
    set_exec(64'h1);
    step("R8 brz lane0", 4'd10, '0, '0, 1'b0, '0, 1'b0, 1'b0, 64'h1);
    set_exec(64'h0000_0000_0010_0000);
    step("R8 brz mid", 4'd10, '0, '0, 1'b0, '0, 1'b0, 1'b0, 64'h0000_0000_0010_0000);
    step("R11 brnz mid", 4'd11, '0, '0, 1'b0, '0, 1'b0, 1'b1, 64'h0000_0000_0010_0000);
  endtask

  task automatic t_unknown;
    set_exec(64'h0123_4567_89AB_CDEF);
    for (int k = 12; k < 16; k++)
      step("R10 unknown", 4'(k), '1, '1, 1'b0, '0, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF);
    set_exec('0);
    step("R10 unknown at zero", 4'd15, '1, '1, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #20000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_if_else();
    t_loop();
    t_breaks();
    t_zero_tests();
    t_unknown();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule